// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox that lets a host processor hand a command to an auxiliary controller core and collect the answer. From the host side it is a 32-bit register bus. The host fills up to four input words, sets a source and a destination pointer, and writes a command word. It then polls a status word until the busy flag drops, and reads up to four result words. The controller side receives a one-cycle doorbell pulse and sees the latched command word, both pointers and the input words. It fills the result words and ends the exchange with a completion strobe. That strobe carries an error flag, an error code and an initiator id.

The control core is a two-state machine. In ST_IDLE, a full-word host write to the command offset takes transition T_ACCEPT to ST_BUSY. That transition latches the command and fires the doorbell. In ST_BUSY, the controller's completion strobe takes transition T_COMPLETE back to ST_IDLE. That transition loads the error fields, copies the command id into the status word, and pulses the host completion interrupt if the command requested one. All other inputs leave the state unchanged.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the status word reads 0, the doorbell and the host interrupt are low, and the latched command, the pointers and both word buffers are 0.
- R2: Full-word host writes load the source pointer at 0x08, the destination pointer at 0x0C, and input word i at 0x80+4i. These values read back at the same offsets and appear on the controller-side outputs (input word chosen by `mcu_in_idx`).
- R3: In ST_IDLE, a full-word write to offset 0x00 moves to ST_BUSY and latches the word on `mcu_cmd`. It also raises `mcu_doorbell` for exactly the one cycle after the write edge. From then on, status bit 0 (busy) reads 1.
- R4: A command write while in ST_BUSY is ignored. It raises no doorbell and leaves `mcu_cmd` unchanged.
- R5: In ST_BUSY, `mcu_done` returns to ST_IDLE in one edge and loads the status fields. The status layout is: bit 0 busy, bit 1 error (from `mcu_err`), bits [7:4] the latched command bits [15:12], bits [15:8] `mcu_init_id`, bits [23:16] `mcu_err_code`, and all other bits 0. `mcu_done` in ST_IDLE has no effect.
- R6: `host_irq` pulses for the one cycle after T_COMPLETE, and only if bit 8 of the latched command is 1.
- R7: A controller result write (`mcu_res_we`) in ST_BUSY stores `mcu_res_data` in result word `mcu_res_idx`, which the host reads at 0x90+4i. Result writes in ST_IDLE are discarded.
- R8: A host write whose byte enables are not all ones is discarded at every offset, including the command offset.
- R9: Reads of offset 0x00 and of every unmapped offset return 0. Host writes to the status offset and to the result words are discarded.
- R10: The bus read data for a read at edge N appears on `bus_rdata` after edge N and reflects register contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_be | input | 4 | Host byte enables |
| bus_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Completion interrupt pulse to host |
| mcu_doorbell | output | 1 | Doorbell pulse to controller |
| mcu_cmd | output | 32 | Latched command word |
| mcu_sptr | output | 32 | Source pointer |
| mcu_dptr | output | 32 | Destination pointer |
| mcu_in_idx | input | 2 | Input word select |
| mcu_in_word | output | 32 | Selected input word |
| mcu_res_we | input | 1 | Result word write strobe |
| mcu_res_idx | input | 2 | Result word index |
| mcu_res_data | input | 32 | Result word data |
| mcu_done | input | 1 | Completion strobe |
| mcu_err | input | 1 | Failure flag with completion |
| mcu_err_code | input | 8 | Error code with completion |
| mcu_init_id | input | 8 | Initiator id with completion |

## Verification
A state machine stuck in ST_BUSY shows up at the ports right away. The next command write then brings no doorbell, and the status word keeps bit 0 set after a completion. A stray return to ST_IDLE shows up too: a second command write fires a doorbell and replaces `mcu_cmd` on the very next edge. Corrupted status fields or result words show up on the next bus read, one cycle later. A wrong interrupt-enable decision shows up as a missing or extra `host_irq` pulse in the cycle right after completion.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int NWORDS = 4;
    localparam int IDX_W  = $clog2(NWORDS);

    localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_SPTR = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DPTR = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_WBUF = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_RBUF = 8'h90;

    localparam int CMD_IOC_BIT = 8;
    localparam int CMD_ID_LSB  = 12;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } mbox_state_e;
endpackage

// File: rtl/mbox_fsm.sv
module mbox_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_req,
    input  logic done_req,
    output logic busy,
    output logic accept,
    output logic complete
);
    import mbox_pkg::*;

    mbox_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            ST_IDLE: if (cmd_req) begin   // T_ACCEPT
                state_d = ST_BUSY;
                accept  = 1'b1;
            end
            ST_BUSY: if (done_req) begin  // T_COMPLETE
                state_d  = ST_IDLE;
                complete = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q == ST_BUSY);
endmodule

// File: rtl/mbox_wordbank.sv
module mbox_wordbank #(
    parameter int NW = 4,
    parameter int DW = 32,
    localparam int IW = $clog2(NW)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IW-1:0]          idx,
    input  logic [DW-1:0]          wdata,
    output logic [NW-1:0][DW-1:0]  words
);
    for (genvar g = 0; g < NW; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                     words[g] <= '0;
            else if (we && idx == IW'(g))   words[g] <= wdata;
        end
    end
endmodule

// File: rtl/mbox_status.sv
module mbox_status #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          complete,
    input  logic [DW-1:0] cmd_in,
    input  logic          err_in,
    input  logic [7:0]    code_in,
    input  logic [7:0]    init_in,
    output logic [DW-1:0] cmd_q,
    output logic          doorbell,
    output logic          host_irq,
    output logic          err_q,
    output logic [7:0]    code_q,
    output logic [7:0]    init_q,
    output logic [3:0]    id_q
);
    import mbox_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            doorbell <= 1'b0;
            host_irq <= 1'b0;
            err_q    <= 1'b0;
            code_q   <= '0;
            init_q   <= '0;
            id_q     <= '0;
        end else begin
            doorbell <= accept;
            host_irq <= complete && cmd_q[CMD_IOC_BIT];
            if (accept) cmd_q <= cmd_in;
            if (complete) begin
                err_q  <= err_in;
                code_q <= code_in;
                init_q <= init_in;
                id_q   <= cmd_q[CMD_ID_LSB +: 4];
            end
        end
    end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_be,
    output logic [31:0] bus_rdata,
    output logic        host_irq,
    output logic        mcu_doorbell,
    output logic [31:0] mcu_cmd,
    output logic [31:0] mcu_sptr,
    output logic [31:0] mcu_dptr,
    input  logic [1:0]  mcu_in_idx,
    output logic [31:0] mcu_in_word,
    input  logic        mcu_res_we,
    input  logic [1:0]  mcu_res_idx,
    input  logic [31:0] mcu_res_data,
    input  logic        mcu_done,
    input  logic        mcu_err,
    input  logic [7:0]  mcu_err_code,
    input  logic [7:0]  mcu_init_id
);
    import mbox_pkg::*;

    localparam int BANK_LSB = IDX_W + 2;

    logic wr_full, hit_cmd, hit_sptr, hit_dptr, hit_wbuf, hit_rbuf, aligned;
    logic busy, accept, complete, err_q;
    logic [7:0] code_q, init_q;
    logic [3:0] id_q;
    logic [IDX_W-1:0] host_idx;
    logic [NWORDS-1:0][DATA_W-1:0] wbuf, rbuf;
    logic [DATA_W-1:0] rd_val, sptr_q, dptr_q, stat_word;

    assign wr_full  = bus_wr && (bus_be == '1);
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign host_idx = bus_addr[BANK_LSB-1:2];
    assign hit_cmd  = (bus_addr == OFF_CMD);
    assign hit_sptr = (bus_addr == OFF_SPTR);
    assign hit_dptr = (bus_addr == OFF_DPTR);
    assign hit_wbuf = aligned && (bus_addr[ADDR_W-1:BANK_LSB] == OFF_WBUF[ADDR_W-1:BANK_LSB]);
    assign hit_rbuf = aligned && (bus_addr[ADDR_W-1:BANK_LSB] == OFF_RBUF[ADDR_W-1:BANK_LSB]);

    mbox_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_req  (wr_full && hit_cmd),
        .done_req (mcu_done),
        .busy     (busy),
        .accept   (accept),
        .complete (complete)
    );

    mbox_status #(.DW(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .complete (complete),
        .cmd_in   (bus_wdata),
        .err_in   (mcu_err),
        .code_in  (mcu_err_code),
        .init_in  (mcu_init_id),
        .cmd_q    (mcu_cmd),
        .doorbell (mcu_doorbell),
        .host_irq (host_irq),
        .err_q    (err_q),
        .code_q   (code_q),
        .init_q   (init_q),
        .id_q     (id_q)
    );

    mbox_wordbank #(.NW(NWORDS), .DW(DATA_W)) u_inbank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_full && hit_wbuf),
        .idx   (host_idx),
        .wdata (bus_wdata),
        .words (wbuf)
    );

    mbox_wordbank #(.NW(NWORDS), .DW(DATA_W)) u_resbank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mcu_res_we && busy),
        .idx   (mcu_res_idx),
        .wdata (mcu_res_data),
        .words (rbuf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sptr_q    <= '0;
            dptr_q    <= '0;
            bus_rdata <= '0;
        end else begin
            if (wr_full && hit_sptr) sptr_q <= bus_wdata;
            if (wr_full && hit_dptr) dptr_q <= bus_wdata;
            if (bus_rd)              bus_rdata <= rd_val;
        end
    end

    assign stat_word = {8'h00, code_q, init_q, id_q, 2'b00, err_q, busy};

    always_comb begin
        rd_val = '0;
        if (bus_addr == OFF_STAT) rd_val = stat_word;
        else if (hit_sptr)        rd_val = sptr_q;
        else if (hit_dptr)        rd_val = dptr_q;
        else if (hit_wbuf)        rd_val = wbuf[host_idx];
        else if (hit_rbuf)        rd_val = rbuf[host_idx];
    end

    assign mcu_sptr    = sptr_q;
    assign mcu_dptr    = dptr_q;
    assign mcu_in_word = wbuf[mcu_in_idx];
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_fire,
    input logic        busy,
    input logic        mcu_doorbell,
    input logic        host_irq,
    input logic [31:0] mcu_cmd,
    input logic        mcu_done,
    input logic        mcu_err,
    input logic        err_q
);
    AST_DOORBELL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && !busy) |=> (mcu_doorbell && busy)); // R3
    AST_DOORBELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_doorbell |=> !mcu_doorbell); // R3
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && busy) |=> (!mcu_doorbell && $stable(mcu_cmd))); // R4
    AST_COMPLETE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mcu_done) |=> (!busy && err_q == $past(mcu_err))); // R5
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(busy && mcu_done && mcu_cmd[8])); // R6
endmodule

bind cmd_mailbox mbox_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_fire     (wr_full && hit_cmd),
    .busy         (busy),
    .mcu_doorbell (mcu_doorbell),
    .host_irq     (host_irq),
    .mcu_cmd      (mcu_cmd),
    .mcu_done     (mcu_done),
    .mcu_err      (mcu_err),
    .err_q        (err_q)
);

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata;
    logic        host_irq, mcu_doorbell;
    logic [31:0] mcu_cmd, mcu_sptr, mcu_dptr, mcu_in_word;
    logic [1:0]  mcu_in_idx;
    logic        mcu_res_we;
    logic [1:0]  mcu_res_idx;
    logic [31:0] mcu_res_data;
    logic        mcu_done, mcu_err;
    logic [7:0]  mcu_err_code, mcu_init_id;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [31:0] m_wbuf [4];
    logic [31:0] m_rbuf [4];
    logic [31:0] m_sptr, m_dptr, m_cmd;
    logic        m_busy, m_err;
    logic [7:0]  m_code, m_init;
    logic [3:0]  m_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_mailbox u_dut (.*);

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h04) return {8'h00, m_code, m_init, m_id, 2'b00, m_err, m_busy};
        if (a == 8'h08) return m_sptr;
        if (a == 8'h0C) return m_dptr;
        if (a >= 8'h80 && a <= 8'h8C && a[1:0] == 2'b00) return m_wbuf[a[3:2]];
        if (a >= 8'h90 && a <= 8'h9C && a[1:0] == 2'b00) return m_rbuf[a[3:2]];
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [31:0] wd, input logic [3:0] be,
                        input logic done, input logic err, input logic [7:0] code,
                        input logic [7:0] init, input logic rwe, input logic [1:0] ridx,
                        input logic [31:0] rdat, input string tag);
        logic [31:0] exp_rd;
        logic exp_db, exp_irq, pre_busy;
        logic [1:0] iidx;
        @(negedge clk);
        iidx = 2'($urandom_range(0, 3));
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; bus_be = be;
        mcu_done = done; mcu_err = err; mcu_err_code = code; mcu_init_id = init;
        mcu_res_we = rwe; mcu_res_idx = ridx; mcu_res_data = rdat; mcu_in_idx = iidx;
        exp_rd = model_read(a);
        pre_busy = m_busy;
        exp_db = 1'b0; exp_irq = 1'b0;
        if (wr && be == 4'hF) begin
            if (a == 8'h08) m_sptr = wd;
            if (a == 8'h0C) m_dptr = wd;
            if (a >= 8'h80 && a <= 8'h8C && a[1:0] == 2'b00) m_wbuf[a[3:2]] = wd;
            if (a == 8'h00 && !pre_busy) begin
                m_busy = 1'b1; m_cmd = wd; exp_db = 1'b1;
            end
        end
        if (pre_busy && done) begin
            m_busy = 1'b0; m_err = err; m_code = code; m_init = init;
            m_id = m_cmd[15:12]; exp_irq = m_cmd[8];
        end
        if (pre_busy && rwe) m_rbuf[ridx] = rdat;
        @(posedge clk);
        #1;
        check({tag, " R3 R4 doorbell"}, 32'(mcu_doorbell), 32'(exp_db));
        check({tag, " R6 host_irq"}, 32'(host_irq), 32'(exp_irq));
        check({tag, " R3 R4 mcu_cmd"}, mcu_cmd, m_cmd);
        check({tag, " R2 R8 pointers"}, mcu_sptr ^ {mcu_dptr[15:0], mcu_dptr[31:16]},
              m_sptr ^ {m_dptr[15:0], m_dptr[31:16]});
        check({tag, " R2 in_word"}, mcu_in_word, m_wbuf[iidx]);
        if (rd) check({tag, " R10 R9 R5 R7 rdata"}, bus_rdata, exp_rd);
        bus_wr = 1'b0; bus_rd = 1'b0; mcu_done = 1'b0; mcu_res_we = 1'b0;
    endtask

    task automatic hwr(input logic [7:0] a, input logic [31:0] d, input string t);
        step(1, 0, a, d, 4'hF, 0, 0, 0, 0, 0, 0, 0, t);
    endtask
    task automatic hrd(input logic [7:0] a, input string t);
        step(0, 1, a, 0, 4'hF, 0, 0, 0, 0, 0, 0, 0, t);
    endtask
    task automatic idle(input string t);
        step(0, 0, 0, 0, 4'hF, 0, 0, 0, 0, 0, 0, 0, t);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] alist [11];
        void'($urandom(32'd1234));
        alist = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h80, 8'h84, 8'h8C, 8'h90, 8'h98, 8'h40, 8'h81};
        foreach (m_wbuf[i]) begin m_wbuf[i] = 0; m_rbuf[i] = 0; end
        m_sptr = 0; m_dptr = 0; m_cmd = 0; m_busy = 0; m_err = 0;
        m_code = 0; m_init = 0; m_id = 0;
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; bus_be = 0;
        mcu_in_idx = 0; mcu_res_we = 0; mcu_res_idx = 0; mcu_res_data = 0;
        mcu_done = 0; mcu_err = 0; mcu_err_code = 0; mcu_init_id = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        hrd(8'h04, "R1 status");
        hrd(8'h90, "R1 rbuf");
        // R2 pointers and input words
        hwr(8'h08, 32'h1000_0000, "R2 sptr");
        hwr(8'h0C, 32'h2000_0040, "R2 dptr");
        for (int i = 0; i < 4; i++) hwr(8'(8'h80 + 4*i), 32'hA0A0_0000 + i, "R2 wbuf");
        hrd(8'h84, "R2 readback");
        // R8 partial writes
        step(1, 0, 8'h08, 32'hDEAD_BEEF, 4'h3, 0, 0, 0, 0, 0, 0, 0, "R8 partial sptr");
        step(1, 0, 8'h00, 32'h0000_1101, 4'h7, 0, 0, 0, 0, 0, 0, 0, "R8 partial cmd");
        hrd(8'h04, "R8 status idle");
        // R7 result write while idle discarded
        step(0, 0, 0, 0, 4'hF, 0, 0, 0, 0, 1, 2'd1, 32'h5555_5555, "R7 idle res");
        hrd(8'h94, "R7 idle res readback");
        // R5 done while idle ignored
        step(0, 0, 0, 0, 4'hF, 1, 1, 8'h77, 8'h66, 0, 0, 0, "R5 idle done");
        hrd(8'h04, "R5 idle status");
        // R3 command with ioc
        hwr(8'h00, 32'h0004_A1C3, "R3 cmd");
        hrd(8'h04, "R3 busy");
        hrd(8'h00, "R9 cmd reads zero");
        // R4 command while busy
        hwr(8'h00, 32'h0000_5022, "R4 busy cmd");
        // R9 writes to status/rbuf discarded
        hwr(8'h04, 32'hFFFF_FFFF, "R9 status write");
        hwr(8'h90, 32'h1234_5678, "R9 rbuf write");
        // R7 result writes
        step(0, 0, 0, 0, 4'hF, 0, 0, 0, 0, 1, 2'd0, 32'hCAFE_0000, "R7 res0");
        step(0, 0, 0, 0, 4'hF, 0, 0, 0, 0, 1, 2'd3, 32'hCAFE_0003, "R7 res3");
        // R5 R6 completion with error, ioc set
        step(0, 0, 0, 0, 4'hF, 1, 1, 8'h5A, 8'h03, 0, 0, 0, "R5 R6 done");
        idle("R6 irq drops");
        hrd(8'h04, "R5 status");
        hrd(8'h90, "R7 res0");
        hrd(8'h9C, "R7 res3");
        hrd(8'h40, "R9 reserved");
        // R6 command without ioc
        hwr(8'h00, 32'h0000_3005, "R6 cmd no ioc");
        step(0, 0, 0, 0, 4'hF, 1, 0, 8'h00, 8'h01, 0, 0, 0, "R6 done no irq");
        hrd(8'h04, "R5 status ok");

        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] a;
            logic [31:0] wd;
            a  = alist[$urandom_range(0, 10)];
            wd = $urandom();
            step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, wd,
                 ($urandom_range(0, 5) == 0) ? 4'($urandom()) : 4'hF,
                 $urandom_range(0, 6) == 0, 1'($urandom()), 8'($urandom()), 8'($urandom()),
                 $urandom_range(0, 2) == 0, 2'($urandom()), $urandom(), "RND");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule